// File: doc/BRIEF.md
# Machine Counter CSR Unit

This block holds the two free-running event counters of a small 32-bit core: one counts clock cycles and the other counts retired instructions. Each counter is 64 bits wide. Software reaches each counter as two 32-bit CSR halves. The block also decodes the CSR address space that belongs to these counters. This covers the writable machine-level halves, the hardware performance counter slots (legal, but hardwired to zero), and an optional bank of user-level read-only copies.

The surrounding CSR file presents an address, a read or write strobe and write data in the same cycle. It takes back combinational read data and an illegal-access flag, and the flag feeds the trap logic. Addresses that do not belong to the counter ranges give zero data and no flag, so another decoder can claim them. The parameter `USER_COPIES` removes the user bank, and any access to that bank then traps.

Top module: `mcnt_csr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both 64-bit counters to zero. Counting resumes from zero on the first edge after reset is released.
- R2: The cycle counter adds one on every clock edge and wraps from all ones to zero.
- R3: The retired-instruction counter adds one on each edge where `retire` is high and holds otherwise.
- R4: A carry out of the low 32 bits reaches the high 32 bits on the same edge.
- R5: Reads return cycle low/high at 0xB00/0xB80 and retired-instruction low/high at 0xB02/0xB82. Addresses with bit 7 set select the high half.
- R6: A write to one of those four addresses replaces that half on the next edge, and the written value wins over the increment. The other half takes its normally incremented value.
- R7: Addresses 0xB03–0xB1F and 0xB83–0xB9F read as zero, raise no flag, and ignore writes.
- R8: With `USER_COPIES`=1, 0xC00/0xC80/0xC02/0xC82 read the same value as the matching machine address in the same cycle. 0xC03–0xC1F and 0xC83–0xC9F read zero with no flag.
- R9: A write to any address in 0xC00–0xC1F or 0xC80–0xC9F raises `csr_illegal` and changes no counter.
- R10: Any access to 0xC01 or 0xC81 raises `csr_illegal` and reads zero.
- R11: With `USER_COPIES`=0, any access to 0xC00–0xC1F or 0xC80–0xC9F raises `csr_illegal` and reads zero.
- R12: `csr_rdata` is zero and `csr_illegal` is low when neither strobe is set, or when the address lies outside the ranges above (this includes 0xB01 and 0xB81).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| retire | input | 1 | One instruction retired this cycle |
| csr_rdata | output | XLEN | Combinational read data |
| csr_illegal | output | 1 | Access must trap |

## Verification
On a single edge, a software write to a counter half can coincide with that counter's own increment. This includes the carry that the increment sends into the unwritten half. The bench provokes this in three ways: it writes the retired-instruction low half while `retire` is high, it writes the high half while `retire` is high, and it presets the cycle counter so that its low half wraps. It then reads both halves on the following cycle. The written half must show exactly the written value, and the other half must show its incremented value.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;

    localparam int CSR_AW = 12;

    // address bits [11:5] select a 32-entry bank
    localparam logic [6:0] BANK_M_LO = 7'h58;  // 0xB00
    localparam logic [6:0] BANK_M_HI = 7'h5C;  // 0xB80
    localparam logic [6:0] BANK_U_LO = 7'h60;  // 0xC00
    localparam logic [6:0] BANK_U_HI = 7'h64;  // 0xC80

    localparam logic [4:0] SLOT_CYCLE   = 5'd0;
    localparam logic [4:0] SLOT_TIMER   = 5'd1;
    localparam logic [4:0] SLOT_INSTRET = 5'd2;

    typedef enum logic [1:0] {
        SEL_CYCLE   = 2'd0,
        SEL_INSTRET = 2'd1,
        SEL_ZERO    = 2'd2,
        SEL_NONE    = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic hi;
        logic user;
        logic illegal;
    } dec_t;

endpackage

// File: rtl/mcnt_decode.sv
module mcnt_decode
    import mcnt_pkg::*;
#(
    parameter bit USER_COPIES = 1'b1
) (
    input  logic [CSR_AW-1:0] addr,
    output dec_t              dec
);

    logic [6:0] bank;
    logic [4:0] slot;
    logic       in_mach;
    logic       in_user;

    always_comb begin
        bank    = addr[CSR_AW-1:5];
        slot    = addr[4:0];
        in_mach = (bank == BANK_M_LO) || (bank == BANK_M_HI);
        in_user = (bank == BANK_U_LO) || (bank == BANK_U_HI);

        dec         = '0;
        dec.sel     = SEL_NONE;
        dec.hi      = addr[7];
        dec.user    = in_user;
        dec.illegal = 1'b0;

        if (in_mach || (in_user && USER_COPIES)) begin
            if (slot == SLOT_CYCLE)        dec.sel = SEL_CYCLE;
            else if (slot == SLOT_INSTRET) dec.sel = SEL_INSTRET;
            else if (slot == SLOT_TIMER)   dec.sel = SEL_NONE;
            else                           dec.sel = SEL_ZERO;
        end

        if (in_user && (!USER_COPIES || slot == SLOT_TIMER)) begin
            dec.sel     = SEL_NONE;
            dec.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/mcnt_counter.sv
module mcnt_counter #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [XLEN-1:0]   wdata,
    output logic [2*XLEN-1:0] value
);

    localparam int CW = 2 * XLEN;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + {{(CW-1){1'b0}}, inc};
        if (wr_lo) st_d.cnt[XLEN-1:0]  = wdata;
        if (wr_hi) st_d.cnt[CW-1:XLEN] = wdata;
        if (rst)   st_d.cnt            = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value = st_q.cnt;

    AST_CNT_CLEAR: assert property (@(posedge clk)
        rst |=> (value == '0));  // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi) |=> (value == $past(value) + {{(CW-1){1'b0}}, $past(inc)}));  // R2

    AST_CNT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi && inc && (&value[XLEN-1:0]))
        |=> (value[CW-1:XLEN] == XLEN'($past(value[CW-1:XLEN]) + 1'b1)));  // R4

    AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (value[XLEN-1:0] == $past(wdata)));  // R6

endmodule

// File: rtl/mcnt_csr_unit.sv
module mcnt_csr_unit
    import mcnt_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit USER_COPIES = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              retire,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal
);

    localparam int CW      = 2 * XLEN;
    localparam int NCNT    = 2;
    localparam int IDX_CYC = 0;
    localparam int IDX_INS = 1;

    dec_t            dec;
    logic [NCNT-1:0] cnt_inc;
    logic [NCNT-1:0] cnt_wr_lo;
    logic [NCNT-1:0] cnt_wr_hi;
    logic [CW-1:0]   cnt_val [NCNT];
    logic            mach_wr;

    mcnt_decode #(.USER_COPIES(USER_COPIES)) u_dec (
        .addr (csr_addr),
        .dec  (dec)
    );

    always_comb begin
        cnt_inc[IDX_CYC] = 1'b1;
        cnt_inc[IDX_INS] = retire;
        mach_wr = csr_wr && !dec.user && !dec.illegal;
        for (int i = 0; i < NCNT; i++) begin
            cnt_wr_lo[i] = mach_wr && (dec.sel == sel_e'(2'(i))) && !dec.hi;
            cnt_wr_hi[i] = mach_wr && (dec.sel == sel_e'(2'(i))) &&  dec.hi;
        end
    end

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            mcnt_counter #(.XLEN(XLEN)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (cnt_inc[g]),
                .wr_lo (cnt_wr_lo[g]),
                .wr_hi (cnt_wr_hi[g]),
                .wdata (csr_wdata),
                .value (cnt_val[g])
            );
        end
    endgenerate

    always_comb begin
        csr_rdata = '0;
        if (csr_rd && !dec.illegal) begin
            case (dec.sel)
                SEL_CYCLE:   csr_rdata = dec.hi ? cnt_val[IDX_CYC][CW-1:XLEN]
                                                : cnt_val[IDX_CYC][XLEN-1:0];
                SEL_INSTRET: csr_rdata = dec.hi ? cnt_val[IDX_INS][CW-1:XLEN]
                                                : cnt_val[IDX_INS][XLEN-1:0];
                default:     csr_rdata = '0;
            endcase
        end
        csr_illegal = ((csr_rd || csr_wr) && dec.illegal) || (csr_wr && dec.user);
    end

    AST_USER_WR_TRAP: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr[11:8] == 4'hC && csr_addr[6:5] == 2'b00) |-> csr_illegal);  // R9

    AST_TIMER_TRAP: assert property (@(posedge clk) disable iff (rst)
        ((csr_rd || csr_wr) && csr_addr[11:8] == 4'hC && csr_addr[6:0] == 7'd1)
        |-> (csr_illegal && csr_rdata == '0));  // R10

    AST_PERF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && !csr_wr && csr_addr[11:8] == 4'hB && csr_addr[6:5] == 2'b00 && csr_addr[4:0] > 5'd2)
        |-> (csr_rdata == '0 && !csr_illegal));  // R7

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (csr_addr[11:8] != 4'hB && csr_addr[11:8] != 4'hC) |-> (csr_rdata == '0 && !csr_illegal));  // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!csr_rd && !csr_wr) |-> (csr_rdata == '0 && !csr_illegal));  // R12

    generate
        if (!USER_COPIES) begin : g_no_user_chk
            AST_NO_USER_TRAP: assert property (@(posedge clk) disable iff (rst)
                ((csr_rd || csr_wr) && csr_addr[11:8] == 4'hC && csr_addr[6:5] == 2'b00)
                |-> (csr_illegal && csr_rdata == '0));  // R11
        end
    endgenerate

endmodule

// File: tb/mcnt_csr_unit_test.sv
module mcnt_csr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        retire = 1'b0;
    logic [31:0] rdata, rdata_min;
    logic        ill, ill_min;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    mcnt_csr_unit #(.XLEN(32), .USER_COPIES(1'b1)) uut (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_rd(rd), .csr_wr(wr),
        .csr_wdata(wdata), .retire(retire), .csr_rdata(rdata), .csr_illegal(ill)
    );

    mcnt_csr_unit #(.XLEN(32), .USER_COPIES(1'b0)) uut_min (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_rd(rd), .csr_wr(wr),
        .csr_wdata(wdata), .retire(retire), .csr_rdata(rdata_min), .csr_illegal(ill_min)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic r, input logic w, input logic [31:0] d);
        addr = a; rd = r; wr = w; wdata = d;
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
        drive(12'h000, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        at_neg();
        drive(a, 1'b0, 1'b1, d);
        @(posedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        drive(a, 1'b1, 1'b0, 32'h0);
        chk(req, rdata, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        at_neg();
        rd_chk("R1 cycle lo in reset", 12'hB00, 32'h0);
        rd_chk("R1 cycle hi in reset", 12'hB80, 32'h0);
        rd_chk("R1 instret lo in reset", 12'hB02, 32'h0);
        rd_chk("R1 instret hi in reset", 12'hB82, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        at_neg();
        rd_chk("R1 first count after reset", 12'hB00, 32'h1);
        @(posedge clk);
        at_neg();
        rd_chk("R2 cycle step", 12'hB00, 32'h2);
    endtask

    task automatic t_wrap();
        csr_write(12'hB80, 32'hFFFF_FFFF);
        csr_write(12'hB00, 32'hFFFF_FFFF);
        at_neg();
        rd_chk("R6 cycle lo written", 12'hB00, 32'hFFFF_FFFF);
        rd_chk("R5 cycle hi written", 12'hB80, 32'hFFFF_FFFF);
        @(posedge clk);
        at_neg();
        rd_chk("R2 cycle wrap lo", 12'hB00, 32'h0);
        rd_chk("R2 cycle wrap hi", 12'hB80, 32'h0);
    endtask

    task automatic t_carry();
        csr_write(12'hB80, 32'h5);
        csr_write(12'hB00, 32'hFFFF_FFFE);
        at_neg();
        rd_chk("R6 write beats increment", 12'hB00, 32'hFFFF_FFFE);
        rd_chk("R6 hi kept", 12'hB80, 32'h5);
        @(posedge clk);
        at_neg();
        rd_chk("R2 lo at ones", 12'hB00, 32'hFFFF_FFFF);
        rd_chk("R4 hi before carry", 12'hB80, 32'h5);
        @(posedge clk);
        at_neg();
        rd_chk("R4 lo after carry", 12'hB00, 32'h0);
        rd_chk("R4 hi after carry", 12'hB80, 32'h6);
    endtask

    task automatic t_instret();
        logic [4:0] pat = 5'b01101;
        csr_write(12'hB02, 32'h0);
        csr_write(12'hB82, 32'h0);
        for (int i = 0; i < 5; i++) begin
            at_neg();
            retire = pat[i];
            @(posedge clk);
        end
        at_neg();
        retire = 1'b0;
        rd_chk("R3 retire count", 12'hB02, 32'h3);
        rd_chk("R5 instret hi", 12'hB82, 32'h0);
        at_neg();
        retire = 1'b1;
        drive(12'hB02, 1'b0, 1'b1, 32'h50);
        @(posedge clk);
        at_neg();
        retire = 1'b0;
        rd_chk("R6 write with retire", 12'hB02, 32'h50);
        retire = 1'b1;
        @(posedge clk);
        at_neg();
        rd_chk("R3 single retire", 12'hB02, 32'h51);
        drive(12'hB82, 1'b0, 1'b1, 32'h7);
        @(posedge clk);
        at_neg();
        retire = 1'b0;
        rd_chk("R6 hi write lo increments", 12'hB02, 32'h52);
        rd_chk("R6 hi written", 12'hB82, 32'h7);
    endtask

    task automatic t_perf();
        csr_write(12'hB03, 32'hAAAA_5555);
        csr_write(12'hB83, 32'h1234_5678);
        at_neg();
        rd_chk("R7 instret untouched", 12'hB02, 32'h52);
        rd_chk("R7 perf lo zero", 12'hB03, 32'h0);
        chk("R7 perf no flag", {31'b0, ill}, 32'h0);
        rd_chk("R7 perf top zero", 12'hB1F, 32'h0);
        rd_chk("R7 perf hi zero", 12'hB9F, 32'h0);
    endtask

    task automatic t_user_read();
        logic [31:0] m;
        at_neg();
        drive(12'hB00, 1'b1, 1'b0, 32'h0);
        m = rdata;
        rd_chk("R8 user cycle lo", 12'hC00, m);
        drive(12'hB80, 1'b1, 1'b0, 32'h0);
        m = rdata;
        rd_chk("R8 user cycle hi", 12'hC80, m);
        rd_chk("R8 user instret lo", 12'hC02, 32'h52);
        rd_chk("R8 user instret hi", 12'hC82, 32'h7);
        rd_chk("R8 user perf zero", 12'hC1F, 32'h0);
        chk("R8 user perf no flag", {31'b0, ill}, 32'h0);
    endtask

    task automatic t_user_write();
        at_neg();
        drive(12'hC02, 1'b0, 1'b1, 32'hDEAD_BEEF);
        chk("R9 user write flag", {31'b0, ill}, 32'h1);
        @(posedge clk);
        at_neg();
        drive(12'hC82, 1'b0, 1'b1, 32'hDEAD_BEEF);
        chk("R9 user hi write flag", {31'b0, ill}, 32'h1);
        @(posedge clk);
        at_neg();
        rd_chk("R9 instret lo unchanged", 12'hB02, 32'h52);
        rd_chk("R9 instret hi unchanged", 12'hB82, 32'h7);
    endtask

    task automatic t_timer();
        at_neg();
        rd_chk("R10 timer read zero", 12'hC01, 32'h0);
        chk("R10 timer read flag", {31'b0, ill}, 32'h1);
        drive(12'hC81, 1'b0, 1'b1, 32'h1);
        chk("R10 timer hi write flag", {31'b0, ill}, 32'h1);
    endtask

    task automatic t_no_user();
        at_neg();
        drive(12'hC00, 1'b1, 1'b0, 32'h0);
        chk("R11 removed copy flag", {31'b0, ill_min}, 32'h1);
        chk("R11 removed copy data", rdata_min, 32'h0);
        drive(12'hC9F, 1'b1, 1'b0, 32'h0);
        chk("R11 removed perf copy flag", {31'b0, ill_min}, 32'h1);
        drive(12'hB00, 1'b1, 1'b0, 32'h0);
        chk("R11 machine still legal", {31'b0, ill_min}, 32'h0);
    endtask

    task automatic t_outside();
        at_neg();
        rd_chk("R12 foreign address", 12'h300, 32'h0);
        chk("R12 foreign no flag", {31'b0, ill}, 32'h0);
        rd_chk("R12 slot 1 machine", 12'hB01, 32'h0);
        chk("R12 slot 1 no flag", {31'b0, ill}, 32'h0);
        rd_chk("R12 past bank", 12'hB20, 32'h0);
        drive(12'hB02, 1'b0, 1'b0, 32'h0);
        chk("R12 idle data", rdata, 32'h0);
        chk("R12 idle flag", {31'b0, ill}, 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap();
        t_carry();
        t_instret();
        t_perf();
        t_user_read();
        t_user_write();
        t_timer();
        t_no_user();
        t_outside();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule